// File: doc/BRIEF.md
# Tagged Result Bus Arbiter

This block shares one 64-bit result bus among eleven producers: six load buffers, two multiply/divide stations and three add stations. A producer announces that a result will be ready by pulsing its request line two cycles before the result is due. The arbiter keeps every request it has accepted until that request is served. In each cycle it chooses one pending requester, giving priority to the smallest tag. It then raises that producer's select line for the broadcast cycle. In that same cycle it places a valid bit, the winner's 4-bit source tag and the winner's data on the bus, where every consumer can compare the tag against the one it is waiting for.

Tags are assigned by producer class. Load buffers take tags 1 through 6, multiply/divide stations take 8 and 9, and add stations take 10 through 12. Tag 0 marks an idle bus. The codes 7, 13, 14 and 15 are never driven. Every count, tag base and width is a parameter, and elaboration checks reject any setting whose tag ranges overlap, include zero, or do not fit in the tag width.

Top module: `rbus_arbiter`

## Requirements
- R1: During and directly after reset, `gnt_o` is all zero, `bus_valid_o` is 0, `bus_tag_o` is 0 and `bus_data_o` is 0.
- R2: Producer index i (bit i of `req_i`/`gnt_o`) carries tag i+1 for indices 0..5 (loads), tag i+2 for indices 6..7 (multiply/divide) and tag i+2 for indices 8..10 (adds).
- R3: A request sampled at rising edge k, when it is the only pending request, appears as a grant and broadcast in the cycle that follows edge k+1, which is two cycles of lead time.
- R4: At most one bit of `gnt_o` is set in any cycle, and `bus_valid_o` is 1 exactly when one bit is set.
- R5: Among pending requests, the smallest tag wins.
- R6: A request that loses stays pending without being raised again, and it is granted in a later cycle. A lower-tag request that arrives later is served before it.
- R7: When no grant is active, `bus_tag_o` is 0 and `bus_data_o` is 0.
- R8: While a grant is active, `bus_data_o` equals the 64-bit slice of `prod_data_i` belonging to the granted producer (bits i*64 +: 64).
- R9: A second request from a producer that is still pending is merged into the first and yields only one grant.
- R10: While `bus_valid_o` is 1, `bus_tag_o` is never 0, 7, 13, 14 or 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 11 | One request pulse per producer, bit i = producer index i |
| prod_data_i | input | 704 | Producer results, slice i*64 +: 64 for producer i |
| gnt_o | output | 11 | One-hot select: the granted producer drives its result this cycle |
| bus_valid_o | output | 1 | Bus carries a result this cycle |
| bus_tag_o | output | 4 | Tag of the granted producer, 0 when idle |
| bus_data_o | output | 64 | Broadcast result, 0 when idle |

## Verification
The hardest case to reach from the ports is a held loser that is overtaken by a lower-tag request arriving one cycle later. The held request must then survive two arbitration rounds without being raised again. A close second is a duplicate request that arrives while the producer is still pending and has to be merged rather than counted twice. Directed sequences produce both cases. One pulses a blocking low-tag request together with the target, and then pulses a second request one cycle later, timed so that it lands on the edge where the blocker is granted. A table of multi-bit request patterns, up to all eleven at once, drains through the priority order while the bench checks every grant cycle and the idle cycle that follows.

// File: rtl/rbus_pkg.sv
package rbus_pkg;

   // Source tag of producer idx, given class sizes and tag bases.
   function automatic int prod_tag(input int idx, input int n_ld, input int n_md,
                                   input int b_ld, input int b_md, input int b_ad);
      if (idx < n_ld)
         return b_ld + idx;
      else if (idx < n_ld + n_md)
         return b_md + (idx - n_ld);
      else
         return b_ad + (idx - n_ld - n_md);
   endfunction

endpackage

// File: rtl/rbus_req_capture.sv
module rbus_req_capture #(
   parameter int N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] win_i,
   output logic [N-1:0] pend_o
);

   logic [N-1:0] pend_q;

   // Accepted requests stay until they win; new pulses merge in.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= (pend_q & ~win_i) | req_i;
   end

   assign pend_o = pend_q;

   // R3
   req_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_i) |=> ((pend_q & $past(req_i)) == $past(req_i)));

   // R6
   loser_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_q & ~win_i)) |=>
         ((pend_q & $past(pend_q & ~win_i)) == $past(pend_q & ~win_i)));

endmodule

// File: rtl/rbus_prio_pick.sv
module rbus_prio_pick #(
   parameter int N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pend_i,
   output logic [N-1:0] win_o
);

   // Lowest set bit wins; index order follows tag order.
   assign win_o = pend_i & (~pend_i + N'(1));

   // R4
   one_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_o));

   // R5
   lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend_i) |-> (((win_o & pend_i) != '0) && (((win_o - N'(1)) & pend_i) == '0)));

endmodule

// File: rtl/rbus_grant_reg.sv
module rbus_grant_reg #(
   parameter int N     = 11,
   parameter int TAG_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N-1:0]       win_i,
   input  logic [N*TAG_W-1:0] tag_tbl_i,
   output logic [N-1:0]       gnt_o,
   output logic               valid_o,
   output logic [TAG_W-1:0]   tag_o
);

   logic [TAG_W-1:0] tag_next;
   logic [N-1:0]     gnt_q;
   logic             valid_q;
   logic [TAG_W-1:0] tag_q;

   always_comb begin
      tag_next = '0;
      for (int i = 0; i < N; i++)
         if (win_i[i])
            tag_next = tag_next | tag_tbl_i[i*TAG_W +: TAG_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q   <= '0;
         valid_q <= 1'b0;
         tag_q   <= '0;
      end else begin
         gnt_q   <= win_i;
         valid_q <= |win_i;
         tag_q   <= tag_next;
      end
   end

   assign gnt_o   = gnt_q;
   assign valid_o = valid_q;
   assign tag_o   = tag_q;

   // R4
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q) && (valid_q == ($countones(gnt_q) == 1)));

endmodule

// File: rtl/rbus_data_mux.sv
module rbus_data_mux #(
   parameter int N      = 11,
   parameter int DATA_W = 64
) (
   input  logic [N-1:0]        gnt_i,
   input  logic [N*DATA_W-1:0] data_i,
   output logic [DATA_W-1:0]   data_o
);

   // AND-OR select; zero when no grant.
   always_comb begin
      data_o = '0;
      for (int i = 0; i < N; i++)
         if (gnt_i[i])
            data_o = data_o | data_i[i*DATA_W +: DATA_W];
   end

endmodule

// File: rtl/rbus_arbiter.sv
module rbus_arbiter #(
   parameter int NUM_LD  = 6,
   parameter int NUM_MD  = 2,
   parameter int NUM_AD  = 3,
   parameter int BASE_LD = 1,
   parameter int BASE_MD = 8,
   parameter int BASE_AD = 10,
   parameter int TAG_W   = 4,
   parameter int DATA_W  = 64,
   localparam int NPROD  = NUM_LD + NUM_MD + NUM_AD
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPROD-1:0]        req_i,
   input  logic [NPROD*DATA_W-1:0] prod_data_i,
   output logic [NPROD-1:0]        gnt_o,
   output logic                    bus_valid_o,
   output logic [TAG_W-1:0]        bus_tag_o,
   output logic [DATA_W-1:0]       bus_data_o
);

   localparam int TAG_MAX = (1 << TAG_W) - 1;

   if (BASE_LD < 1) begin : g_bad_zero
      $error("tag 0 is reserved for idle");
   end
   if (BASE_LD + NUM_LD > BASE_MD || BASE_MD + NUM_MD > BASE_AD) begin : g_bad_order
      $error("tag ranges overlap or are out of order");
   end
   if (BASE_AD + NUM_AD - 1 > TAG_MAX) begin : g_bad_width
      $error("tags do not fit TAG_W");
   end
   if (NUM_LD < 1 || NUM_MD < 1 || NUM_AD < 1) begin : g_bad_count
      $error("each producer class needs at least one member");
   end

   logic [NPROD*TAG_W-1:0] tag_tbl;
   logic [NPROD-1:0]       pend;
   logic [NPROD-1:0]       win;

   for (genvar g = 0; g < NPROD; g++) begin : g_tag
      assign tag_tbl[g*TAG_W +: TAG_W] =
         TAG_W'(rbus_pkg::prod_tag(g, NUM_LD, NUM_MD, BASE_LD, BASE_MD, BASE_AD));
   end

   rbus_req_capture #(.N(NPROD)) cap_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .win_i  (win),
      .pend_o (pend)
   );

   rbus_prio_pick #(.N(NPROD)) pick_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .win_o  (win)
   );

   rbus_grant_reg #(.N(NPROD), .TAG_W(TAG_W)) greg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_i     (win),
      .tag_tbl_i (tag_tbl),
      .gnt_o     (gnt_o),
      .valid_o   (bus_valid_o),
      .tag_o     (bus_tag_o)
   );

   rbus_data_mux #(.N(NPROD), .DATA_W(DATA_W)) dmux_i (
      .gnt_i  (gnt_o),
      .data_i (prod_data_i),
      .data_o (bus_data_o)
   );

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid_o |-> (bus_tag_o == '0 && bus_data_o == '0 && gnt_o == '0));

   // R10
   legal_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o |-> (bus_tag_o != '0 && bus_tag_o >= TAG_W'(BASE_LD) &&
                       bus_tag_o <= TAG_W'(BASE_AD + NUM_AD - 1) &&
                       !(bus_tag_o >= TAG_W'(BASE_LD + NUM_LD) && bus_tag_o < TAG_W'(BASE_MD))));

   // R3
   lead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0 && $countones(req_i) == 1) |=> ##1 (gnt_o == $past(req_i, 2)));

endmodule

// File: tb/rbus_arbiter_tb_top.sv
module rbus_arbiter_tb_top;

   localparam int NP = 11;
   localparam int DW = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    req = '0;
   logic [NP*DW-1:0] pdata;
   logic [NP-1:0]    gnt;
   logic             bvalid;
   logic [3:0]       btag;
   logic [DW-1:0]    bdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   rbus_arbiter dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .prod_data_i (pdata),
      .gnt_o       (gnt),
      .bus_valid_o (bvalid),
      .bus_tag_o   (btag),
      .bus_data_o  (bdata)
   );

   function automatic logic [DW-1:0] val_of(input int idx);
      return 64'hC0DE_0000_0000_0000 | (64'(idx + 1) * 64'h0000_0101_0101_0101);
   endfunction

   // R2: expected tag mapping
   function automatic logic [3:0] exp_tag(input int idx);
      if (idx < 6) return 4'(idx + 1);
      return 4'(idx + 2);
   endfunction

   always_comb
      for (int i = 0; i < NP; i++) pdata[i*DW +: DW] = val_of(i);

   task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic expect_grant(input int idx, input string rq);
      chk(gnt == NP'(1) << idx, rq, 64'(gnt), 64'(NP'(1) << idx));
      chk(bvalid == 1'b1, "R4", 64'(bvalid), 64'd1);
      chk(btag == exp_tag(idx), "R2", 64'(btag), 64'(exp_tag(idx)));
      chk(bdata == val_of(idx), "R8", bdata, val_of(idx));
   endtask

   task automatic expect_idle(input string rq);
      chk(gnt == '0 && bvalid == 1'b0, rq, 64'(gnt), 64'd0);
      chk(btag == 4'd0 && bdata == '0, "R7", bdata | 64'(btag), 64'd0);
   endtask

   localparam logic [NP-1:0] PATS [8] = '{
      11'b000_0000_0001, 11'b100_0000_0000, 11'b000_1000_0000, 11'b101_0100_0010,
      11'b111_1111_1111, 11'b011_0000_0000, 11'b000_0010_0001, 11'b110_1101_0110
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state, requests ignored while in reset
      req = '1;
      repeat (3) @(negedge clk);
      expect_idle("R1");
      req = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_idle("R1");

      // Vector table: R3 lead time, R5 lowest-first order, R6 retention
      for (int v = 0; v < 8; v++) begin
         logic [NP-1:0] left;
         left = PATS[v];
         req = PATS[v];
         @(negedge clk);
         req = '0;
         while (left != '0) begin
            int lo;
            lo = 0;
            for (int b = NP - 1; b >= 0; b--) if (left[b]) lo = b;
            @(negedge clk);
            expect_grant(lo, "R5");
            left[lo] = 1'b0;
         end
         @(negedge clk);
         expect_idle("R7");
      end

      // R3: a single request, not yet granted one edge later
      req = 11'b000_0001_0000;
      @(negedge clk);
      req = '0;
      expect_idle("R3");
      @(negedge clk);
      expect_grant(4, "R3");
      @(negedge clk);
      expect_idle("R3");

      // R9: repeat request while still pending is merged
      req = 11'b001_0000_0001;
      @(negedge clk);
      req = 11'b001_0000_0000;
      @(negedge clk);
      req = '0;
      expect_grant(0, "R9");
      @(negedge clk);
      expect_grant(8, "R9");
      @(negedge clk);
      expect_idle("R9");

      // R6: held loser overtaken by a later lower-tag request
      req = 11'b011_0000_0000;
      @(negedge clk);
      req = 11'b000_0000_0100;
      @(negedge clk);
      req = '0;
      expect_grant(8, "R6");
      @(negedge clk);
      expect_grant(2, "R6");
      @(negedge clk);
      expect_grant(9, "R6");
      @(negedge clk);
      expect_idle("R6");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule